// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

The arbiter decides which of up to six processor agents, or one host, owns a shared external bus. Each agent raises its own request bit; agent index k (bit k of the request vector) carries the 3-bit agent ID k+1, so bit 0 is ID 1 and bit 5 is ID 6. ID 0 is never granted and reports "no agent owns the bus". A static mode input chooses between fixed priority and rotating priority. It must be wired the same way for every agent.

Ownership is sticky. The current master keeps the bus while it keeps requesting, unless a host request arrives or another agent raises its core-priority request. A lock input pins the current master for indivisible read-modify-write sequences. Each change of owner passes through exactly one cycle in which nobody owns the bus. The host outranks every agent and keeps its grant for as long as it holds its request.

Top module: `mp_bus_arbiter`

## Requirements
- R1: During and right after reset with no request pending, `grant_o` is 0, `master_id_o` is 0 and `host_grant_o` is 0.
- R2: With `rot_mode_i` low, among simultaneous eligible requests the lowest agent index (lowest ID) is granted.
- R3: With `rot_mode_i` high, the search starts at the agent just above the last granted one and wraps, so the last owner has the lowest priority.
- R4: A host request makes an unlocked master release the bus. After one idle cycle `host_grant_o` rises, and no agent grant is active while it is high.
- R5: `host_grant_o` stays high while `host_req_i` stays high. After it drops, one idle cycle follows and then pending agent requests are arbitrated.
- R6: `grant_o` is one-hot or zero, and any change of owner goes through exactly one cycle with no grant.
- R7: A master whose request stays high keeps the bus while no host request and no core-priority request from another agent is pending.
- R8: While `lock_i` is high the current master keeps the bus, even against a host request, a core-priority request or the drop of its own request.
- R9: A requesting agent whose `prio_i` bit is set forces an unlocked master whose own `prio_i` bit is clear to release. In the next arbitration, agents with a set priority bit win over the others.
- R10: `master_id_o` is the granted agent's index plus 1, and 0 whenever no agent holds the bus, including while the host holds it.
- R11: A grant rises one clock edge after a request is seen by an idle arbiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rot_mode_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| req_i | input | 6 | Agent requests, bit k is the agent with ID k+1; absent agents held at 0 |
| prio_i | input | 6 | Core-priority request, bit k for agent k |
| host_req_i | input | 1 | Host bus request |
| lock_i | input | 1 | Bus lock held by the current master |
| grant_o | output | 6 | One-hot agent grant |
| master_id_o | output | 3 | ID of the granting agent, 0 if none |
| host_grant_o | output | 1 | Host owns the bus |

## Verification
Every output is registered, so a stimulus applied in one cycle shows at the outputs right after the following rising edge. A handover shows as one cycle with zero grant and the new owner one edge later. The driver applies inputs on the falling edge and queues the outputs expected after the next rising edge. The monitor samples shortly after that rising edge, so every comparison falls exactly one edge after its stimulus. Sequences of steps cover the idle gap, host entry and exit, and the two priority orders.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_HOST = 2'd2
  } arb_st_e;
endpackage

// File: rtl/arb_req_filter.sv
module arb_req_filter #(
  parameter int N_AGENTS = 6
) (
  input  logic [N_AGENTS-1:0] req_i,
  input  logic [N_AGENTS-1:0] prio_i,
  output logic [N_AGENTS-1:0] cand_o,
  output logic                any_o,
  output logic                any_prio_o
);
  logic [N_AGENTS-1:0] hot;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_hot
    assign hot[g] = req_i[g] & prio_i[g];
  end

  assign any_prio_o = |hot;
  assign any_o      = |req_i;
  // priority requesters shadow plain requesters
  assign cand_o     = any_prio_o ? hot : req_i;
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_AGENTS = 6,
  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                rot_i,
  input  logic [IDX_W-1:0]    last_i,
  input  logic [N_AGENTS-1:0] cand_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                valid_o
);
  always_comb begin
    int start;
    idx_o   = '0;
    valid_o = 1'b0;
    start   = rot_i ? (int'(last_i) + 1) : 0;
    for (int k = 0; k < N_AGENTS; k++) begin
      int j;
      j = (start + k) % N_AGENTS;
      if (!valid_o && cand_i[j]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int N_AGENTS = 6,
  parameter int ID_W = 3,
  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic [N_AGENTS-1:0] prio_i,
  input  logic                host_req_i,
  input  logic                lock_i,
  input  logic                any_prio_i,
  input  logic                pick_valid_i,
  input  logic [IDX_W-1:0]    pick_idx_i,
  output logic [IDX_W-1:0]    last_o,
  output logic [N_AGENTS-1:0] grant_o,
  output logic [ID_W-1:0]     master_id_o,
  output logic                host_grant_o
);
  arb_st_e          st_q, st_d;
  logic [IDX_W-1:0] own_q, own_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             own_req, own_prio, preempt, release_bus;

  assign own_req  = req_i[own_q];
  assign own_prio = prio_i[own_q];
  // another agent's core-priority request only counts against a non-priority master
  assign preempt  = host_req_i | (any_prio_i & ~own_prio);
  assign release_bus = ~lock_i & (preempt | ~own_req);

  always_comb begin
    st_d   = st_q;
    own_d  = own_q;
    last_d = last_q;
    unique case (st_q)
      ST_IDLE: begin
        if (host_req_i) begin
          st_d = ST_HOST;
        end else if (pick_valid_i) begin
          st_d   = ST_OWN;
          own_d  = pick_idx_i;
          last_d = pick_idx_i;
        end
      end
      ST_OWN: begin
        if (release_bus) st_d = ST_IDLE;
      end
      ST_HOST: begin
        if (!host_req_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      own_q  <= '0;
      last_q <= IDX_W'(N_AGENTS - 1);
    end else begin
      st_q   <= st_d;
      own_q  <= own_d;
      last_q <= last_d;
    end
  end

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_gnt
    assign grant_o[g] = (st_q == ST_OWN) && (own_q == IDX_W'(g));
  end

  assign host_grant_o = (st_q == ST_HOST);
  assign master_id_o  = (st_q == ST_OWN) ? ID_W'(own_q) + ID_W'(1) : '0;
  assign last_o       = last_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R6
  AST_HANDOVER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |=> (grant_o == '0 || $stable(grant_o))); // R6
  AST_HOST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_grant_o |-> (grant_o == '0)); // R4
  AST_HOST_ENTRY_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_grant_o) |-> ($past(grant_o) == '0)); // R4
  AST_HOST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_grant_o && host_req_i) |=> host_grant_o); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && grant_o != '0) |=> $stable(grant_o)); // R8
  AST_ID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |-> (master_id_o == '0)); // R10
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter #(
  parameter int N_AGENTS = 6,
  parameter int ID_W = 3,
  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rot_mode_i,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic [N_AGENTS-1:0] prio_i,
  input  logic                host_req_i,
  input  logic                lock_i,
  output logic [N_AGENTS-1:0] grant_o,
  output logic [ID_W-1:0]     master_id_o,
  output logic                host_grant_o
);
  logic [N_AGENTS-1:0] cand;
  logic                any_req, any_prio, pick_valid;
  logic [IDX_W-1:0]    pick_idx, last_idx;

  arb_req_filter #(.N_AGENTS(N_AGENTS)) u_filter (
    .req_i      (req_i),
    .prio_i     (prio_i),
    .cand_o     (cand),
    .any_o      (any_req),
    .any_prio_o (any_prio)
  );

  arb_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .rot_i   (rot_mode_i),
    .last_i  (last_idx),
    .cand_i  (cand),
    .idx_o   (pick_idx),
    .valid_o (pick_valid)
  );

  arb_ctrl #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .prio_i       (prio_i),
    .host_req_i   (host_req_i),
    .lock_i       (lock_i),
    .any_prio_i   (any_prio),
    .pick_valid_i (pick_valid & any_req),
    .pick_idx_i   (pick_idx),
    .last_o       (last_idx),
    .grant_o      (grant_o),
    .master_id_o  (master_id_o),
    .host_grant_o (host_grant_o)
  );

  initial begin
    AST_ID_RANGE: assert (N_AGENTS < (1 << ID_W)); // R10
  end
endmodule

// File: tb/sim_mp_bus_arbiter.sv
module sim_mp_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rot = 1'b0;
  logic [5:0] req = '0;
  logic [5:0] prio = '0;
  logic       host = 1'b0;
  logic       lock = 1'b0;
  logic [5:0] gnt;
  logic [2:0] mid;
  logic       hgnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] g;
    logic       h;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  mp_bus_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .rot_mode_i(rot), .req_i(req), .prio_i(prio),
    .host_req_i(host), .lock_i(lock), .grant_o(gnt), .master_id_o(mid),
    .host_grant_o(hgnt)
  );

  function automatic logic [2:0] id_of(input logic [5:0] g);
    for (int k = 0; k < 6; k++) if (g[k]) return 3'(k + 1);
    return 3'd0;
  endfunction

  // bit k of a vector = agent ID k+1
  function automatic logic [5:0] ag(input int id);
    return 6'(1) << (id - 1);
  endfunction

  task automatic step(input logic [5:0] r, input logic [5:0] p, input logic h,
                      input logic l, input logic rm, input logic [5:0] eg,
                      input logic eh, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; prio = p; host = h; lock = l; rot = rm;
    e.g = eg; e.h = eh; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (gnt !== e.g || hgnt !== e.h || mid !== id_of(e.g)) begin
          n_fail++;
          $display("FAIL %s: grant=%b host=%b id=%0d expected grant=%b host=%b id=%0d",
                   e.tag, gnt, hgnt, mid, e.g, e.h, id_of(e.g));
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (gnt !== '0 || hgnt !== 1'b0 || mid !== 3'd0) begin
      n_fail++;
      $display("FAIL R1 reset: grant=%b host=%b id=%0d expected 0 0 0", gnt, hgnt, mid);
    end
    rst_n = 1'b1;
    // fixed priority
    step('0, '0, 0, 0, 0, '0, 0, "R1 idle after reset");
    step(ag(3)|ag(5), '0, 0, 0, 0, ag(3), 0, "R2 R11 lowest ID wins");
    step(ag(3)|ag(5), '0, 0, 0, 0, ag(3), 0, "R7 master retains");
    step(ag(5), '0, 0, 0, 0, '0, 0, "R6 idle gap on release");
    step(ag(5), '0, 0, 0, 0, ag(5), 0, "R6 next owner after gap");
    step(ag(1)|ag(5), '0, 0, 0, 0, ag(5), 0, "R7 no preempt by higher priority");
    step(ag(1)|ag(5), ag(1), 0, 0, 0, '0, 0, "R9 core priority forces release");
    step(ag(1)|ag(5), ag(1), 0, 0, 0, ag(1), 0, "R9 priority agent granted");
    step(ag(1)|ag(5), '0, 1, 1, 0, ag(1), 0, "R8 lock beats host");
    step(ag(5), '0, 1, 1, 0, ag(1), 0, "R8 lock beats own request drop");
    step(ag(5), '0, 1, 0, 0, '0, 0, "R4 host forces release");
    step(ag(5), '0, 1, 0, 0, '0, 1, "R4 host granted after gap");
    step(ag(5), '0, 1, 0, 0, '0, 1, "R5 host grant held");
    step(ag(5), '0, 0, 0, 0, '0, 0, "R5 host release gap");
    step(ag(5), '0, 0, 0, 0, ag(5), 0, "R5 agents arbitrated after host");
    // rotating priority, last owner ID 5
    step(ag(2)|ag(6), '0, 0, 0, 1, '0, 0, "R6 release in rotating mode");
    step(ag(2)|ag(6), '0, 0, 0, 1, ag(6), 0, "R3 search starts above last owner");
    step(ag(2), '0, 0, 0, 1, '0, 0, "R6 release gap");
    step(ag(3)|ag(6), '0, 0, 0, 1, ag(3), 0, "R3 wrap, last owner lowest");
    step(ag(3)|ag(6), '0, 0, 0, 1, ag(3), 0, "R7 rotating retain");
    step(ag(6), '0, 0, 0, 1, '0, 0, "R6 release gap");
    step(ag(6), '0, 0, 0, 1, ag(6), 0, "R10 ID 6 reported");
    step('0, '0, 0, 0, 1, '0, 0, "R10 zero ID when idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule